// File: doc/BRIEF.md
# Serial GPIO master shift engine

This block drives a serial link to a chain of external shift registers so that a few wires carry many slow general-purpose pins. Each frame opens with a load strobe that makes the external chain latch its parallel inputs. A serial clock then moves one output bit out and one input bit in for every pin. Frames repeat for as long as the enable bit is set. Every frame first copies the parallel output word, so software can rewrite it at any time. The captured input word appears all at once when a frame ends.

A 32-bit control word configures the engine. It holds an enable flag, a pin count given in groups of eight, and a 16-bit clock divider. The serial clock runs at the system clock divided by 2*(divider+1). The pin count and the divider are taken once at the start of each frame. Pin p maps to bit p of the flat input and output words, which is bit p mod 32 of 32-bit bank p/32. The block has two read-back words. One holds the captured input values. The other holds the output word that the current (or last) frame drives.

Top module: `sgpm_top`

## Requirements
- R1: While reset is held and on the first cycle after it, `sclk`, `sload`, `sdout` and `frame_done` are 0, and `in_data` and `out_rdata` are all zeros.
- R2: A control write sets enable from bit 0, the group count from bits 10:6 and the divider from bits 31:16. The pin count is 8 times the group count, clamped to `MAX_PINS`. A group count of 0 starts no frame.
- R3: Every serial clock period, measured from one rising `sclk` to the next within a frame, lasts 2*(div+1) system clocks. A divider of 0 gives 2 cycles.
- R4: Each frame begins with `sload` high for exactly 2*(div+1) system clocks. `sclk` stays low during that time, and the load comes before the first data bit.
- R5: Bits move in pin order from pin npins-1 down to pin 0. `sdout` changes only when `sclk` falls or at the start of a frame, and it stays stable while `sclk` is high. `sdin` is sampled at the rising `sclk`.
- R6: `in_data` bit p holds the `sdin` value sampled in pin p's slot, and bits at or above the pin count read 0. `in_data` changes only in the single cycle in which `frame_done` pulses, and `frame_done` is high for exactly one cycle per frame.
- R7: `out_rdata` holds the output word the current frame drives. It is copied from the output register at frame start. A mid-frame write to the output register does not change the frame in progress or `out_rdata` until the next frame.
- R8: With enable set, frames follow one another without further writes. If enable is cleared during a frame, that frame completes, and the engine then idles with `sclk` and `sload` low.
- R9: The divider and the group count are latched at frame start. A control write during a frame does not change the timing of the frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_wr | input | 1 | Write strobe for the control word |
| ctrl_wdata | input | 32 | Control word: enable bit 0, group count 10:6, divider 31:16 |
| out_wr | input | 1 | Write strobe for the output word |
| out_wdata | input | MAX_PINS | Output value per pin, bit p = pin p |
| out_rdata | output | MAX_PINS | Output word driven by the current or last frame |
| in_data | output | MAX_PINS | Input values captured by the last completed frame |
| frame_done | output | 1 | One-cycle pulse when `in_data` is updated |
| sclk | output | 1 | Serial clock, idle low |
| sload | output | 1 | Load strobe at the head of each frame |
| sdout | output | 1 | Serial data to the chain |
| sdin | input | 1 | Serial data from the chain |

## Verification
After a control write with enable set, the load strobe rises two clock edges later. One edge stores the control word and the next starts the frame. Each later event lands on a multiple of div+1 cycles: one cycle registers `frame_done` and the new `in_data` after the last high half of `sclk`, and `out_rdata` changes on the frame-start edge. The bench therefore never samples on a fixed cycle offset. It measures periods and strobe widths by counting system clocks between `sclk` and `sload` edges, waits for the `frame_done` pulse, and reads every output at the falling system clock. The loopback sets `sdin` to `sdout` XOR a constant, which makes the expected input word a pure function of the output word.

// File: rtl/sgpm_pkg.sv
package sgpm_pkg;

    localparam int CTRL_W  = 32;
    localparam int EN_BIT  = 0;
    localparam int CNT_LSB = 6;
    localparam int CNT_W   = 5;
    localparam int DIV_LSB = 16;
    localparam int DIV_W   = 16;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_LOW  = 2'd2,
        ST_HIGH = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic [CNT_W-1:0] groups;
        logic             en;
    } ctrl_t;

    function automatic ctrl_t decode_ctrl(input logic [CTRL_W-1:0] w);
        ctrl_t c;
        c.en     = w[EN_BIT];
        c.groups = w[CNT_LSB +: CNT_W];
        c.div    = w[DIV_LSB +: DIV_W];
        return c;
    endfunction

endpackage

// File: rtl/sgpm_clkdiv.sv
module sgpm_clkdiv
    import sgpm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt;

    assign tick = run && (cnt == div);

    always_ff @(posedge clk) begin
        if (rst || !run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R3: the half-period counter never passes the latched divider
    a_r3_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt <= div));

    // R9: the divider seen by the counter holds for the whole frame
    a_r9_div_hold: assert property (@(posedge clk) disable iff (rst)
        (run && $past(run)) |-> $stable(div));

endmodule

// File: rtl/sgpm_sequencer.sv
module sgpm_sequencer
    import sgpm_pkg::*;
#(
    parameter int MAX_PINS = 64,
    localparam int BI_W    = $clog2(MAX_PINS)
) (
    input  logic             clk,
    input  logic             rst,
    input  ctrl_t            ctrl,
    input  logic             tick,
    output logic             run,
    output logic [DIV_W-1:0] div_q,
    output logic             start,
    output logic             sample,
    output logic             done,
    output logic             shifting,
    output logic             sclk,
    output logic             sload,
    output logic [BI_W-1:0]  bit_idx
);

    localparam int PW = CNT_W + 3;
    localparam logic [PW-1:0] MAXP = PW'(MAX_PINS);

    seq_state_e      state;
    logic            half;
    logic [PW-1:0]   req_pins;
    logic [PW-1:0]   npins;
    logic [BI_W-1:0] first_idx;

    always_comb begin
        req_pins  = {ctrl.groups, 3'b000};
        npins     = (req_pins > MAXP) ? MAXP : req_pins;
        first_idx = BI_W'(npins - 1'b1);
    end

    assign start    = (state == ST_IDLE) && ctrl.en && (ctrl.groups != '0);
    assign run      = (state != ST_IDLE);
    assign sample   = (state == ST_LOW) && tick;
    assign done     = (state == ST_HIGH) && tick && (bit_idx == '0);
    assign shifting = (state == ST_LOW) || (state == ST_HIGH);
    assign sclk     = (state == ST_HIGH);
    assign sload    = (state == ST_LOAD);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            div_q   <= '0;
            bit_idx <= '0;
            half    <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        state   <= ST_LOAD;
                        div_q   <= ctrl.div;
                        bit_idx <= first_idx;
                        half    <= 1'b0;
                    end
                end
                ST_LOAD: begin
                    if (tick) begin
                        if (half) state <= ST_LOW;
                        else      half  <= 1'b1;
                    end
                end
                ST_LOW: begin
                    if (tick) state <= ST_HIGH;
                end
                ST_HIGH: begin
                    if (tick) begin
                        if (bit_idx == '0) begin
                            state <= ST_IDLE;
                        end else begin
                            bit_idx <= bit_idx - 1'b1;
                            state   <= ST_LOW;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R8: without enable the engine stays idle
    a_r8_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && !ctrl.en) |=> (state == ST_IDLE));

    // R5: the clock low half only ends on a divider tick
    a_r5_low_hold: assert property (@(posedge clk) disable iff (rst)
        (state == ST_LOW && !tick) |=> (state == ST_LOW));

endmodule

// File: rtl/sgpm_datapath.sv
module sgpm_datapath #(
    parameter int MAX_PINS = 64,
    localparam int BI_W    = $clog2(MAX_PINS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic                sample,
    input  logic                done,
    input  logic                shifting,
    input  logic [BI_W-1:0]     bit_idx,
    input  logic [MAX_PINS-1:0] out_word,
    input  logic                sdin,
    output logic                sdout,
    output logic [MAX_PINS-1:0] out_rdata,
    output logic [MAX_PINS-1:0] in_data,
    output logic                frame_done
);

    logic [MAX_PINS-1:0] cap;

    assign sdout = shifting && out_rdata[bit_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            out_rdata  <= '0;
            cap        <= '0;
            in_data    <= '0;
            frame_done <= 1'b0;
        end else begin
            frame_done <= done;
            if (start) begin
                out_rdata <= out_word;
                cap       <= '0;
            end else if (sample) begin
                cap[bit_idx] <= sdin;
            end
            if (done) in_data <= cap;
        end
    end

    // R6: captured word moves only with the end-of-frame strobe
    a_r6_in_hold: assert property (@(posedge clk) disable iff (rst)
        !done |=> $stable(in_data));

    // R6: completion pulse lasts one cycle
    a_r6_done_pulse: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> !frame_done);

    // R7: driven-word copy changes only at frame start
    a_r7_rdata_hold: assert property (@(posedge clk) disable iff (rst)
        !start |=> $stable(out_rdata));

endmodule

// File: rtl/sgpm_top.sv
module sgpm_top
    import sgpm_pkg::*;
#(
    parameter int MAX_PINS = 64
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                ctrl_wr,
    input  logic [31:0]         ctrl_wdata,
    input  logic                out_wr,
    input  logic [MAX_PINS-1:0] out_wdata,
    output logic [MAX_PINS-1:0] out_rdata,
    output logic [MAX_PINS-1:0] in_data,
    output logic                frame_done,
    output logic                sclk,
    output logic                sload,
    output logic                sdout,
    input  logic                sdin
);

    localparam int BI_W = $clog2(MAX_PINS);

    ctrl_t               ctrl_q;
    logic [MAX_PINS-1:0] out_q;
    logic                ctrl_unused;
    logic                tick, run, start, sample, done, shifting;
    logic [DIV_W-1:0]    div_q;
    logic [BI_W-1:0]     bit_idx;

    assign ctrl_unused = ^{ctrl_wdata[CNT_LSB-1:EN_BIT+1], ctrl_wdata[DIV_LSB-1:CNT_LSB+CNT_W]};

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            out_q  <= '0;
        end else begin
            if (ctrl_wr) ctrl_q <= decode_ctrl(ctrl_wdata);
            if (out_wr)  out_q  <= out_wdata;
        end
    end

    sgpm_clkdiv u_div (
        .clk  (clk),
        .rst  (rst),
        .run  (run),
        .div  (div_q),
        .tick (tick)
    );

    sgpm_sequencer #(.MAX_PINS(MAX_PINS)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .ctrl     (ctrl_q),
        .tick     (tick),
        .run      (run),
        .div_q    (div_q),
        .start    (start),
        .sample   (sample),
        .done     (done),
        .shifting (shifting),
        .sclk     (sclk),
        .sload    (sload),
        .bit_idx  (bit_idx)
    );

    sgpm_datapath #(.MAX_PINS(MAX_PINS)) u_dp (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .sample     (sample),
        .done       (done),
        .shifting   (shifting),
        .bit_idx    (bit_idx),
        .out_word   (out_q),
        .sdin       (sdin),
        .sdout      (sdout),
        .out_rdata  (out_rdata),
        .in_data    (in_data),
        .frame_done (frame_done)
    );

endmodule

// File: tb/tb_sgpm_top.sv
`timescale 1ns/1ps
module tb_sgpm_top;

    localparam int MP = 64;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ctrl_wr = 1'b0;
    logic [31:0]   ctrl_wdata = '0;
    logic          out_wr = 1'b0;
    logic [MP-1:0] out_wdata = '0;
    logic [MP-1:0] out_rdata, in_data;
    logic          frame_done, sclk, sload, sdout, sdin;
    logic          inv_q = 1'b0;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    assign sdin = sdout ^ inv_q;

    sgpm_top #(.MAX_PINS(MP)) dut (
        .clk(clk), .rst(rst), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
        .out_wr(out_wr), .out_wdata(out_wdata), .out_rdata(out_rdata),
        .in_data(in_data), .frame_done(frame_done), .sclk(sclk),
        .sload(sload), .sdout(sdout), .sdin(sdin)
    );

    // monitors of the serial side
    int cyc = 0;
    int load_t0 = 0, load_w = 0, load_rises = 0;
    int prev_rise = 0, pmin = 0, pmax = 0, hi_viol = 0;
    logic have_prev = 1'b0;
    logic rise_val = 1'b0;
    logic [MP-1:0] obs = '0;

    always @(posedge clk) cyc++;

    always @(posedge sload) begin
        load_t0 = cyc;
        have_prev = 1'b0;
        pmin = 1000000;
        pmax = 0;
        obs = '0;
        load_rises++;
    end

    always @(negedge sload) load_w = cyc - load_t0;

    always @(posedge sclk) begin
        if (have_prev) begin
            if (cyc - prev_rise < pmin) pmin = cyc - prev_rise;
            if (cyc - prev_rise > pmax) pmax = cyc - prev_rise;
        end
        prev_rise = cyc;
        have_prev = 1'b1;
        rise_val = sdout;
        obs = {obs[MP-2:0], sdout};
    end

    always @(negedge clk) if (!rst && sclk === 1'b1 && sdout !== rise_val) hi_viol++;

    task automatic chk(input logic ok, input string what, input logic [MP-1:0] act, input logic [MP-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    function automatic int pins_of(input int groups);
        int p;
        p = groups * 8;
        return (p > MP) ? MP : p;
    endfunction

    function automatic logic [MP-1:0] mask_of(input int np);
        logic [MP-1:0] m;
        m = '0;
        for (int i = 0; i < MP; i++) if (i < np) m[i] = 1'b1;
        return m;
    endfunction

    task automatic write_ctrl(input logic en, input int groups, input int div);
        @(negedge clk);
        ctrl_wr = 1'b1;
        ctrl_wdata = {div[15:0], 5'd0, groups[4:0], 5'd0, en};
        @(negedge clk);
        ctrl_wr = 1'b0;
    endtask

    task automatic write_out(input logic [MP-1:0] w);
        @(negedge clk);
        out_wr = 1'b1;
        out_wdata = w;
        @(negedge clk);
        out_wr = 1'b0;
    endtask

    task automatic wait_done();
        int n;
        n = 0;
        @(negedge clk);
        while (!frame_done && n < 20000) begin
            @(negedge clk);
            n++;
        end
        if (!frame_done) chk(1'b0, "R6 frame_done never pulsed", 0, 1);
    endtask

    task automatic frame_checks(input int div, input int groups, input logic [MP-1:0] word, input logic inv);
        int np, h2;
        logic [MP-1:0] m, exp_in;
        np = pins_of(groups);
        h2 = 2 * (div + 1);
        m = mask_of(np);
        exp_in = (word ^ {MP{inv}}) & m;
        chk(in_data == exp_in, "R6 captured input word", in_data, exp_in);
        chk((obs & m) == (word & m), "R5 serial order pin high to low", obs & m, word & m);
        chk(load_w == h2, "R4 load strobe width", MP'(load_w), MP'(h2));
        if (np > 1) begin
            chk(pmin == h2, "R3 shortest serial period", MP'(pmin), MP'(h2));
            chk(pmax == h2, "R3 longest serial period", MP'(pmax), MP'(h2));
        end
    endtask

    task automatic run_case(input int div, input int groups, input logic [MP-1:0] word, input logic inv);
        int rises0, h2;
        h2 = 2 * (div + 1);
        inv_q = inv;
        write_out(word);
        write_ctrl(1'b1, groups, div);
        @(posedge sload);
        write_ctrl(1'b0, groups, div);
        wait_done();
        frame_checks(div, groups, word, inv);
        chk(out_rdata == word, "R7 driven word read-back", out_rdata, word);
        rises0 = load_rises;
        repeat (3 * h2 + 10) @(negedge clk);
        chk(load_rises == rises0 && sclk == 1'b0 && sload == 1'b0,
            "R8 idle after enable cleared mid-frame", MP'(load_rises), MP'(rises0));
    endtask

    initial begin
        #(8 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [MP-1:0] wa, wb, prev_in;
        int r0;
        void'($urandom(32'h5eed_0042));
        repeat (4) @(negedge clk);
        chk(sclk == 0 && sload == 0 && sdout == 0 && frame_done == 0, "R1 serial pins at reset",
            MP'({sclk, sload, sdout, frame_done}), '0);
        rst = 1'b0;
        @(negedge clk);
        chk(in_data == '0, "R1 input word after reset", in_data, '0);
        chk(out_rdata == '0, "R1 read-back after reset", out_rdata, '0);
        chk(sclk == 0 && sload == 0, "R1 idle lines after reset", MP'({sclk, sload}), '0);
        load_rises = 0;

        // directed: fastest clock, one group, and a clamped count
        run_case(0, 1, 64'h0000_0000_0000_00A5, 1'b0);
        run_case(2, 3, 64'h0123_4567_89AB_CDEF, 1'b1);
        run_case(0, 31, 64'hF0E1_D2C3_B4A5_9687, 1'b0);   // R2 count clamps to 64 pins

        // R2: zero groups start nothing
        r0 = load_rises;
        write_ctrl(1'b1, 0, 0);
        repeat (60) @(negedge clk);
        chk(load_rises == r0 && sclk == 0, "R2 zero group count starts no frame", MP'(load_rises), MP'(r0));
        write_ctrl(1'b0, 0, 0);

        // R8: frames repeat while enabled
        inv_q = 1'b0;
        write_out(64'h0000_0000_0000_3C5A);
        r0 = load_rises;
        write_ctrl(1'b1, 2, 0);
        wait_done();
        wait_done();
        @(posedge sload);
        write_ctrl(1'b0, 2, 0);
        wait_done();
        chk(load_rises - r0 == 3, "R8 back-to-back frames while enabled", MP'(load_rises - r0), 64'd3);
        chk(in_data == 64'h3C5A, "R6 input word after repeated frames", in_data, 64'h3C5A);

        // R7, R9: mid-frame rewrites of divider and output word
        wa = 64'h0000_0000_00C3_9E1F;
        wb = 64'h0000_0000_0071_4BD2;
        inv_q = 1'b1;
        write_out(wa);
        prev_in = in_data;
        write_ctrl(1'b1, 3, 1);
        @(negedge sload);
        write_ctrl(1'b1, 3, 3);
        write_out(wb);
        chk(out_rdata == wa, "R7 read-back unchanged by mid-frame write", out_rdata, wa);
        chk(in_data == prev_in, "R6 input word held during frame", in_data, prev_in);
        wait_done();
        frame_checks(1, 3, wa, 1'b1);
        @(posedge sload);
        write_ctrl(1'b0, 3, 3);
        chk(out_rdata == wb, "R7 read-back takes new word at next frame", out_rdata, wb);
        wait_done();
        frame_checks(3, 3, wb, 1'b1);   // R9 new divider applies from this frame

        // random cases
        for (int k = 0; k < 6; k++) begin
            int d, g;
            logic [MP-1:0] w;
            logic iv;
            d = int'($urandom % 6);
            g = 1 + int'($urandom % 8);
            w = {$urandom, $urandom};
            iv = 1'($urandom % 2);
            run_case(d, g, w, iv);
        end

        chk(hi_viol == 0, "R5 sdout stable while sclk high", MP'(hi_viol), '0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule